// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Direction Register

This block is a general-purpose I/O port of six pins attached to a simple synchronous register bus. Software writes an output latch and a direction register, each holding one bit per pin. The block then produces an output value and an output enable for every pad. A direction bit of 1 turns a pin into a driven output. A direction bit of 0 leaves the pin as an input, and its level is sampled through a two-flop synchronizer.

Each pin can be handed to a serial peripheral with a per-pin select line. While the select is high, the peripheral's own value and enable drive the pad. The read path does not change with ownership: a read of the data register returns the latch for pins whose direction bit is 1 and the synchronized pin level for pins whose direction bit is 0. Reset clears the direction register, so every pin starts as an input. Reset leaves the output latch untouched, so software can load it before it enables a driver and no glitch appears on the pin.

Top module: `gpio_dir_port`

## Requirements
- R1: Register bits [5:0] map to pins 5..0. Bits [7:6] always read as 0. Address 0x0 selects the data register and address 0x1 selects the direction register. A read of any other address returns 0x00.
- R2: When a pin is not overridden, pin_oe_o equals its direction bit (1 = drive) and pin_o equals its latch bit.
- R3: An active-low reset (rst_ni = 0) clears every direction bit, which turns all pin enables off, and clears rdata_o to 0x00.
- R4: Reset does not alter the output latch. In simulation the latch starts at 6'b101101, and it still holds its pre-reset value after a reset.
- R5: When per_sel_i[n] is 1, pin_o[n] and pin_oe_o[n] follow per_out_i[n] and per_oe_i[n], and the direction and latch bits have no effect on that pin.
- R6: A read of the data register returns the latch bit where the direction bit is 1 and the synchronized pin level where it is 0, whatever the value of per_sel_i.
- R7: A write to the data register updates the latch whatever the direction bits are.
- R8: The direction register can be written and read back.
- R9: Read data appears on rdata_o on the clock edge that samples rd_en_i and holds until the next read. A read in the same cycle as a write to the same register returns the value from before the write.
- R10: A pin level sampled at clock edge k first shows up in a data-register read that is sampled at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 6 | Pad input levels |
| pin_o | output | 6 | Pad output values |
| pin_oe_o | output | 6 | Pad output enables |
| per_sel_i | input | 6 | Peripheral owns the pin |
| per_out_i | input | 6 | Peripheral output value |
| per_oe_i | input | 6 | Peripheral output enable |

## Verification
The collision that matters happens when a write and a read reach the same register in one cycle. The registered read must return the old contents, and a changed direction bit only takes effect in the read mux on the next read. The bench provokes this with back-to-back and simultaneous write/read operations to both registers, and with random mixes of operations while pins toggle and peripheral selects change. Every clock, a behavioural model that keeps the synchronizer as a two-entry queue compares rdata_o, pin_o and pin_oe_o against the design.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;
  localparam int unsigned PinsDef  = 6;
  localparam int unsigned BusWDef  = 8;
  localparam int unsigned AddrWDef = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned PINS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] data_i,
  input  logic [PINS-1:0] dir_i,
  input  logic [PINS-1:0] per_sel_i,
  input  logic [PINS-1:0] per_out_i,
  input  logic [PINS-1:0] per_oe_i,
  output logic [PINS-1:0] pin_o,
  output logic [PINS-1:0] pin_oe_o
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign pin_o[p]    = per_sel_i[p] ? per_out_i[p] : data_i[p];
    assign pin_oe_o[p] = per_sel_i[p] ? per_oe_i[p]  : dir_i[p];

    // R5: peripheral owns the driver
    p_override_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_sel_i[p] |-> (pin_oe_o[p] == per_oe_i[p] && pin_o[p] == per_out_i[p]));
    // R2: register-driven pin
    p_reg_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !per_sel_i[p] |-> (pin_oe_o[p] == dir_i[p] && pin_o[p] == data_i[p]));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_dir_pkg::*;
#(
  parameter int unsigned             PINS      = 6,
  parameter int unsigned             BUS_W     = 8,
  parameter int unsigned             ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]       DATA_ADDR = 'h0,
  parameter logic [ADDR_W-1:0]       DIR_ADDR  = 'h1,
  parameter logic [PINS-1:0]         DATA_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [PINS-1:0]   pin_sync_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [PINS-1:0]   data_o,
  output logic [PINS-1:0]   dir_o
);
  reg_sel_e         sel;
  logic [PINS-1:0]  data_q = DATA_INIT;  // no reset by intent
  logic [PINS-1:0]  dir_q;
  logic [BUS_W-1:0] rd_val, rdata_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[BUS_W-1:PINS];

  always_comb begin
    if (addr_i == DATA_ADDR)     sel = SEL_DATA;
    else if (addr_i == DIR_ADDR) sel = SEL_DIR;
    else                         sel = SEL_NONE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni && wr_en_i && sel == SEL_DATA) data_q <= wdata_i[PINS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             dir_q <= '0;
    else if (wr_en_i && sel == SEL_DIR)      dir_q <= wdata_i[PINS-1:0];
  end

  // data read: latch where output, pin where input
  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_DATA: rd_val[PINS-1:0] = (dir_q & data_q) | (~dir_q & pin_sync_i);
      SEL_DIR:  rd_val[PINS-1:0] = dir_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign data_o  = data_q;
  assign dir_o   = dir_q;

  p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BUS_W-1:PINS] == '0);
  p_unmapped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_NONE) |=> rdata_o == '0);
  p_dir_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> dir_q == '0);
  p_data_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_DATA) |=> data_q == $past(wdata_i[PINS-1:0]));
  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel == SEL_DATA) |=> $stable(data_q));
  p_dir_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_DIR) |=> dir_q == $past(wdata_i[PINS-1:0]));
  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  p_rd_mix_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_DATA) |=>
      rdata_o[PINS-1:0] == (($past(dir_q) & $past(data_q)) | (~$past(dir_q) & $past(pin_sync_i))));
endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port
  import gpio_dir_pkg::*;
#(
  parameter int unsigned       PINS      = PinsDef,
  parameter int unsigned       BUS_W     = BusWDef,
  parameter int unsigned       ADDR_W    = AddrWDef,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h1,
  parameter logic [PINS-1:0]   DATA_INIT = 6'b101101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  input  logic [PINS-1:0]   per_sel_i,
  input  logic [PINS-1:0]   per_out_i,
  input  logic [PINS-1:0]   per_oe_i
);
  localparam int unsigned SyncStages = 2;

  logic [PINS-1:0] pin_sync, data_lat, dir_bits;

  gpio_sync #(.WIDTH(PINS), .STAGES(SyncStages)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(
    .PINS(PINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .DATA_INIT(DATA_INIT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .rdata_o   (rdata_o),
    .data_o    (data_lat),
    .dir_o     (dir_bits)
  );

  gpio_pin_mux #(.PINS(PINS)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_lat),
    .dir_i    (dir_bits),
    .per_sel_i(per_sel_i),
    .per_out_i(per_out_i),
    .per_oe_i (per_oe_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );
endmodule

// File: tb/gpio_dir_port_tb_top.sv
module gpio_dir_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] pin = '0, pin_o, pin_oe;
  logic [5:0] psel = '0, pout = '0, poe = '0;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R3";

  always #4 clk = ~clk;  // 125 MHz

  gpio_dir_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .per_sel_i(psel), .per_out_i(pout), .per_oe_i(poe)
  );

  // behavioural reference
  logic [5:0] m_lat = 6'b101101;   // R4: simulated power-up latch
  logic [5:0] m_dir = '0;
  logic [7:0] m_rd  = '0;
  logic [5:0] sync_q[$] = '{6'h0, 6'h0};

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] nxt;
    if (!rst_n) begin
      m_dir = '0; m_rd = '0; sync_q = '{6'h0, 6'h0};
    end else begin
      nxt = m_rd;
      if (rd) begin
        if (addr == 4'h0) begin
          nxt = 8'h00;
          for (int b = 0; b < 6; b++) nxt[b] = m_dir[b] ? m_lat[b] : sync_q[0][b];
        end else if (addr == 4'h1) nxt = {2'b00, m_dir};
        else nxt = 8'h00;
      end
      if (wr && addr == 4'h0) m_lat = wdata[5:0];
      if (wr && addr == 4'h1) m_dir = wdata[5:0];
      void'(sync_q.pop_front());
      sync_q.push_back(pin);
      m_rd = nxt;
    end
  end

  task automatic cmp(string what, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [5:0] e_o, e_oe;
    for (int b = 0; b < 6; b++) begin
      e_o[b]  = psel[b] ? pout[b] : m_lat[b];
      e_oe[b] = psel[b] ? poe[b]  : m_dir[b];
    end
    cmp("rdata", rdata, m_rd);
    cmp("pin_o", {2'b00, pin_o}, {2'b00, e_o});
    cmp("pin_oe", {2'b00, pin_oe}, {2'b00, e_oe});
  end

  task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 4'h0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R3"; idle(3);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(2);
    cur_req = "R4";                      // latch survived power-up reset
    op(1, 0, 4'h1, 8'h3F); op(0, 1, 4'h0, 8'h00); idle(1);
    cur_req = "R1";
    op(1, 0, 4'h1, 8'hFF); op(0, 1, 4'h1, 8'h00); op(0, 1, 4'h7, 8'h00);
    op(0, 1, 4'hF, 8'h00); idle(1);
    cur_req = "R7";
    op(1, 0, 4'h1, 8'h00); op(1, 0, 4'h0, 8'hD5); pin = 6'h0A;
    idle(2); op(0, 1, 4'h0, 8'h00); op(1, 0, 4'h1, 8'h3F); op(0, 1, 4'h0, 8'h00); idle(1);
    cur_req = "R8";
    op(1, 0, 4'h1, 8'h2A); op(0, 1, 4'h1, 8'h00); op(1, 0, 4'h1, 8'h15); op(0, 1, 4'h1, 8'h00);
    cur_req = "R2"; idle(2);
    cur_req = "R6";
    op(1, 0, 4'h1, 8'h0F); pin = 6'h33; idle(2); op(0, 1, 4'h0, 8'h00); idle(1);
    cur_req = "R5";
    psel = 6'h05; pout = 6'h3F; poe = 6'h01; idle(1);
    op(0, 1, 4'h0, 8'h00); psel = 6'h3F; pout = 6'h00; poe = 6'h2A;
    op(0, 1, 4'h0, 8'h00); psel = 6'h00; idle(1);
    cur_req = "R9";
    op(1, 1, 4'h0, 8'h3C); op(1, 1, 4'h0, 8'h03); op(1, 1, 4'h1, 8'h30);
    op(1, 1, 4'h1, 8'h00); idle(3);
    cur_req = "R10";
    op(1, 0, 4'h1, 8'h00);
    for (int k = 0; k < 6; k++) begin
      pin = 6'(k * 11); op(0, 1, 4'h0, 8'h00); op(0, 1, 4'h0, 8'h00); op(0, 1, 4'h0, 8'h00);
    end
    cur_req = "R3";
    op(1, 0, 4'h1, 8'h3F); op(1, 0, 4'h0, 8'h19); op(0, 1, 4'h1, 8'h00);
    @(negedge clk); #1 rst_n = 1'b0; wr = 0; rd = 0;
    idle(2);
    @(negedge clk); #1 rst_n = 1'b1;
    op(0, 1, 4'h1, 8'h00);
    cur_req = "R4";
    op(1, 0, 4'h1, 8'h3F); op(0, 1, 4'h0, 8'h00); idle(1);
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      pin  = 6'($urandom); psel = 6'($urandom); pout = 6'($urandom); poe = 6'($urandom);
      op(1'($urandom), 1'($urandom), 4'($urandom_range(0, 2)), 8'($urandom));
    end
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule